// File: doc/BRIEF.md
# XT-Attached Disk Host Register Interface

This block is the host-facing register front end of an 8-bit disk controller that plugs into an XT-style I/O bus. The host sees four byte-wide ports: data, status (a write there resets the interface), controller-select, and an interrupt/DMA enable mask. A command starts with a select write. The host then writes a six-byte control block through the data port while the controller holds REQ. The block reports each bus phase through REQ, I/O and C/D status bits. Every command ends with a completion byte that the host reads from the data port, and that read returns the interface to idle.

Executing the command is not part of this block. The collected control block goes to a command engine over a valid/ready handshake. The engine answers with a one-cycle done pulse, an error flag with a sense code, and an optional stream of result bytes. Back-pressure rules: `dcb_valid` stays high with `dcb_bytes` held steady until `dcb_ready` is sampled high. `tx_ready` is high only while the engine phase is active and no result byte is held. A result byte is accepted on a cycle where `tx_valid` and `tx_ready` are both high, and it is held until the host reads it.

Top module: `xt_disk_host_if`

## Requirements
- R1: After reset the status byte (port offset 1) reads 0x00, and `irq`, `drq` and `dcb_valid` are low.
- R2: A write to port offset 2 sets status to 0x0D (BSY bit3, C/D bit2, REQ bit0). It arms reception of exactly six control bytes, and it restarts the byte count if a block was partly received.
- R3: Control bytes are stored in arrival order, with byte k at `dcb_bytes[8k+7:8k]`. The sixth byte clears REQ and C/D (status 0x08) and raises `dcb_valid`. `dcb_valid` and `dcb_bytes` then hold until `dcb_ready` is sampled high.
- R4: A data-port write while REQ is clear is rejected. The rejection sets the completion error bit and loads sense code 0x20.
- R5: An engine done pulse sets status to 0x0F (REQ, I/O bit1, C/D, BSY). If mask bit1 is set, status bit5 is also set and `irq` goes high. If mask bit1 is clear, `irq` stays low.
- R6: In the completion phase a data-port read returns the completion byte. Bit5 of that byte is control-byte-1 bit5 (drive select) and bit1 is the error flag. The read clears status to 0x00, lowers `irq` on the next cycle, and returns to idle. A select write clears the error flag.
- R7: A write to port offset 1 clears the sense code, clears pending interrupts and returns to idle with status 0x00.
- R8: Reads of port offset 2 return 0xFF, and status bit7 always reads back 0.
- R9: A result byte taken from the engine sets status to 0x0B (REQ, I/O, BSY). If mask bit0 is set, status bit4 and `drq` are also set. A data-port read returns the byte and drops status back to 0x08.
- R10: An engine done pulse with the error flag set sets the completion error bit and loads `sense_code` from `eng_sense`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 2 | Port offset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access; side effects occur at the closing edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |
| irq | output | 1 | Level interrupt request |
| drq | output | 1 | DMA request (status bit4) |
| dcb_valid | output | 1 | Control block available to the engine |
| dcb_ready | input | 1 | Engine accepts the control block |
| dcb_bytes | output | 48 | Six control bytes, byte 0 in the low bits |
| eng_done | input | 1 | Command finished, one-cycle pulse |
| eng_err | input | 1 | Command failed, sampled with `eng_done` |
| eng_sense | input | 8 | Sense code, sampled with `eng_done` when `eng_err` is high |
| tx_valid | input | 1 | Engine offers a result byte |
| tx_ready | output | 1 | Interface can take a result byte |
| tx_data | input | 8 | Result byte |
| sense_code | output | 8 | Current sense code, visible to the engine |

## Verification
The properties assume the command engine pulses `eng_done` only after it has taken the control block and while no result byte is waiting for the host. They also assume the host never raises read and write strobes in the same cycle. The stimulus respects both: every engine action waits for `dcb_valid` to fall and for the previous result byte to be read. Bus accesses are issued one at a time from tasks, each strobe lasting exactly one cycle.

// File: rtl/xtd_pkg.sv
package xtd_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_HAND = 3'd2,
    PH_EXEC = 3'd3,
    PH_DONE = 3'd4
  } xtd_phase_e;

  localparam int ST_REQ = 0;
  localparam int ST_IO  = 1;
  localparam int ST_CD  = 2;
  localparam int ST_BSY = 3;
  localparam int ST_DRQ = 4;
  localparam int ST_IRQ = 5;
  localparam int ST_ACT = 7;

  localparam logic [1:0] OFS_DATA = 2'd0;
  localparam logic [1:0] OFS_CTRL = 2'd1;
  localparam logic [1:0] OFS_SEL  = 2'd2;
  localparam logic [1:0] OFS_MASK = 2'd3;

  localparam int MASK_DMA_BIT = 0;
  localparam int MASK_IRQ_BIT = 1;
  localparam int COMP_ERR_BIT = 1;
  localparam int COMP_DRV_BIT = 5;
  localparam int DRV_SEL_BYTE = 1;
  localparam int DRV_SEL_BIT  = 5;

  localparam logic [7:0] SENSE_NONE   = 8'h00;
  localparam logic [7:0] SENSE_BADCMD = 8'h20;
  localparam logic [7:0] OPEN_BUS     = 8'hFF;
endpackage

// File: rtl/xtd_dcb_collect.sv
module xtd_dcb_collect #(
  parameter int NB = 6,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            abort,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic            collecting,
  output logic            last_byte,
  output logic [NB*DW-1:0] dcb_flat
);
  localparam int IW = $clog2(NB + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NB - 1);

  logic [IW-1:0] idx_q;
  logic          take;

  assign take      = wr_en && collecting;
  assign last_byte = take && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collecting <= 1'b0;
      idx_q      <= '0;
    end else if (abort) begin
      collecting <= 1'b0;
      idx_q      <= '0;
    end else if (arm) begin
      collecting <= 1'b1;
      idx_q      <= '0;
    end else if (take) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) collecting <= 1'b0;
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [DW-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n) byte_q <= '0;
      else if (!abort && !arm && take && idx_q == IW'(i)) byte_q <= wr_data;
    end
    assign dcb_flat[i*DW +: DW] = byte_q;
  end
endmodule

// File: rtl/xtd_phase_ctrl.sv
module xtd_phase_ctrl
  import xtd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_wr,
  input  logic          rst_wr,
  input  logic          data_rd,
  input  logic          reject,
  input  logic          last_byte,
  input  logic          dcb_ready,
  input  logic          eng_done,
  input  logic          eng_err,
  input  logic [DW-1:0] eng_sense,
  input  logic          irq_en,
  output xtd_phase_e    phase,
  output logic          irq_pend,
  output logic          comp_err,
  output logic [DW-1:0] sense
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      irq_pend <= 1'b0;
      comp_err <= 1'b0;
      sense    <= DW'(SENSE_NONE);
    end else if (rst_wr) begin
      phase    <= PH_IDLE;
      irq_pend <= 1'b0;
      sense    <= DW'(SENSE_NONE);
    end else if (sel_wr) begin
      phase    <= PH_CMD;
      irq_pend <= 1'b0;
      comp_err <= 1'b0;
    end else begin
      if (reject) begin
        comp_err <= 1'b1;
        sense    <= DW'(SENSE_BADCMD);
      end
      if (data_rd) irq_pend <= 1'b0;
      case (phase)
        PH_CMD:  if (last_byte) phase <= PH_HAND;
        PH_HAND: if (dcb_ready) phase <= PH_EXEC;
        PH_EXEC: if (eng_done) begin
          phase <= PH_DONE;
          if (eng_err) begin
            comp_err <= 1'b1;
            sense    <= eng_sense;
          end
          if (irq_en) irq_pend <= 1'b1;
        end
        PH_DONE: if (data_rd) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xtd_tx_hold.sv
module xtd_tx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          open_win,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          pop,
  output logic          tx_ready,
  output logic          held,
  output logic [DW-1:0] held_byte
);
  assign tx_ready = open_win && !held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_byte <= '0;
    end else if (flush) begin
      held <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      held      <= 1'b1;
      held_byte <= tx_data;
    end else if (pop && held) begin
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/xtd_status_gen.sv
module xtd_status_gen
  import xtd_pkg::*;
#(
  parameter int DW = 8
) (
  input  xtd_phase_e    phase,
  input  logic          held,
  input  logic          dma_en,
  input  logic          irq_pend,
  input  logic [DW-1:0] held_byte,
  input  logic          comp_err,
  input  logic          drv_sel,
  input  logic [1:0]    rd_addr,
  output logic          drq,
  output logic [DW-1:0] rdata
);
  logic [7:0] status_full;
  logic [7:0] comp_byte;

  always_comb begin
    status_full = '0;
    case (phase)
      PH_CMD: begin
        status_full[ST_REQ] = 1'b1;
        status_full[ST_CD]  = 1'b1;
        status_full[ST_BSY] = 1'b1;
      end
      PH_HAND: status_full[ST_BSY] = 1'b1;
      PH_EXEC: begin
        status_full[ST_BSY] = 1'b1;
        status_full[ST_REQ] = held;
        status_full[ST_IO]  = held;
        status_full[ST_DRQ] = held && dma_en;
      end
      PH_DONE: begin
        status_full[ST_REQ] = 1'b1;
        status_full[ST_IO]  = 1'b1;
        status_full[ST_CD]  = 1'b1;
        status_full[ST_BSY] = 1'b1;
        status_full[ST_IRQ] = irq_pend;
      end
      default: status_full = '0;
    endcase
    status_full[ST_ACT] = (phase != PH_IDLE);
  end

  assign drq = status_full[ST_DRQ];

  always_comb begin
    comp_byte = '0;
    comp_byte[COMP_DRV_BIT] = drv_sel;
    comp_byte[COMP_ERR_BIT] = comp_err;
  end

  always_comb begin
    case (rd_addr)
      OFS_DATA: begin
        if (phase == PH_DONE)              rdata = DW'(comp_byte);
        else if (phase == PH_EXEC && held) rdata = held_byte;
        else                               rdata = DW'(OPEN_BUS);
      end
      OFS_CTRL: begin
        rdata = DW'(status_full);
        rdata[ST_ACT] = 1'b0;
      end
      default:  rdata = DW'(OPEN_BUS);
    endcase
  end
endmodule

// File: rtl/xt_disk_host_if.sv
module xt_disk_host_if
  import xtd_pkg::*;
#(
  parameter int NB = 6,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [DW-1:0]    io_wdata,
  output logic [DW-1:0]    io_rdata,
  output logic             irq,
  output logic             drq,
  output logic             dcb_valid,
  input  logic             dcb_ready,
  output logic [NB*DW-1:0] dcb_bytes,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic [DW-1:0]    eng_sense,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [DW-1:0]    tx_data,
  output logic [DW-1:0]    sense_code
);
  logic       data_wr, data_rd, sel_wr, rst_wr, mask_wr;
  logic [1:0] mask_q;
  logic       collecting, last_byte, reject;
  logic       irq_pend, comp_err, held;
  logic [DW-1:0] held_byte;
  xtd_phase_e phase;

  assign data_wr = io_wr && io_addr == OFS_DATA;
  assign rst_wr  = io_wr && io_addr == OFS_CTRL;
  assign sel_wr  = io_wr && io_addr == OFS_SEL;
  assign mask_wr = io_wr && io_addr == OFS_MASK;
  assign data_rd = io_rd && io_addr == OFS_DATA;
  assign reject  = data_wr && !collecting && !sel_wr && !rst_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= io_wdata[1:0];
  end

  xtd_dcb_collect #(.NB(NB), .DW(DW)) u_collect (
    .clk(clk), .rst_n(rst_n), .arm(sel_wr), .abort(rst_wr),
    .wr_en(data_wr), .wr_data(io_wdata),
    .collecting(collecting), .last_byte(last_byte), .dcb_flat(dcb_bytes)
  );

  xtd_phase_ctrl #(.DW(DW)) u_phase (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .rst_wr(rst_wr),
    .data_rd(data_rd), .reject(reject), .last_byte(last_byte),
    .dcb_ready(dcb_ready), .eng_done(eng_done), .eng_err(eng_err),
    .eng_sense(eng_sense), .irq_en(mask_q[MASK_IRQ_BIT]),
    .phase(phase), .irq_pend(irq_pend), .comp_err(comp_err), .sense(sense_code)
  );

  xtd_tx_hold #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .flush(sel_wr || rst_wr),
    .open_win(phase == PH_EXEC), .tx_valid(tx_valid), .tx_data(tx_data),
    .pop(data_rd && phase == PH_EXEC),
    .tx_ready(tx_ready), .held(held), .held_byte(held_byte)
  );

  xtd_status_gen #(.DW(DW)) u_status (
    .phase(phase), .held(held), .dma_en(mask_q[MASK_DMA_BIT]),
    .irq_pend(irq_pend), .held_byte(held_byte), .comp_err(comp_err),
    .drv_sel(dcb_bytes[DRV_SEL_BYTE*DW + DRV_SEL_BIT]), .rd_addr(io_addr),
    .drq(drq), .rdata(io_rdata)
  );

  assign irq       = irq_pend;
  assign dcb_valid = (phase == PH_HAND);
endmodule

// File: rtl/xtd_host_if_chk.sv
module xtd_host_if_chk #(
  parameter int NB = 6,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       io_addr,
  input logic             io_wr,
  input logic             io_rd,
  input logic [DW-1:0]    io_rdata,
  input logic             irq,
  input logic             dcb_valid,
  input logic             dcb_ready,
  input logic [NB*DW-1:0] dcb_bytes,
  input logic             eng_done,
  input logic [DW-1:0]    sense_code
);
  // R8
  status_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 2'd1) |-> !io_rdata[7]);

  // R8
  jumper_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 2'd2) |-> io_rdata == DW'(8'hFF));

  // R3
  dcb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcb_valid && !dcb_ready && !(io_wr && (io_addr == 2'd1 || io_addr == 2'd2)))
    |=> (dcb_valid && $stable(dcb_bytes)));

  // R5
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(eng_done));

  // R6
  comp_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && io_rd && io_addr == 2'd0) |=> !irq);

  // R7
  reset_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd1) |=> (!irq && sense_code == '0));
endmodule

bind xt_disk_host_if xtd_host_if_chk #(.NB(NB), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_rdata(io_rdata), .irq(irq), .dcb_valid(dcb_valid), .dcb_ready(dcb_ready),
  .dcb_bytes(dcb_bytes), .eng_done(eng_done), .sense_code(sense_code)
);

// File: tb/tb_xt_disk_host_if.sv
module tb_xt_disk_host_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic irq, drq, dcb_valid, tx_ready;
  logic dcb_ready = 1'b0;
  logic [47:0] dcb_bytes;
  logic eng_done = 1'b0, eng_err = 1'b0, tx_valid = 1'b0;
  logic [7:0] eng_sense = '0, tx_data = '0;
  logic [7:0] sense_code;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  xt_disk_host_if dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .irq(irq), .drq(drq),
    .dcb_valid(dcb_valid), .dcb_ready(dcb_ready), .dcb_bytes(dcb_bytes),
    .eng_done(eng_done), .eng_err(eng_err), .eng_sense(eng_sense),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .sense_code(sense_code)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected read data at the negedge inside each read.
  always @(negedge clk) begin
    if (io_rd) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read, actual %0h expected none", io_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 64'(io_rdata), 64'(e));
      end
    end
  end

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    exp_q.push_back(e); tag_q.push_back(t);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic send_dcb(input logic [47:0] blk);
    for (int i = 0; i < 6; i++) host_wr(2'd0, blk[i*8 +: 8]);
  endtask

  task automatic take_dcb();
    @(posedge clk); #1; dcb_ready = 1'b1;
    @(posedge clk); #1; dcb_ready = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d, input string t);
    @(posedge clk); #1;
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk); chk(t, 64'(tx_ready), 64'd1);
    @(posedge clk); #1; tx_valid = 1'b0;
  endtask

  task automatic finish_cmd(input logic err, input logic [7:0] s);
    @(posedge clk); #1;
    eng_done = 1'b1; eng_err = err; eng_sense = s;
    @(posedge clk); #1;
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", 64'(irq), 64'd0);
    chk("R1 drq", 64'(drq), 64'd0);
    chk("R1 dcb_valid", 64'(dcb_valid), 64'd0);
    host_rd(2'd1, 8'h00, "R1 status");
    host_rd(2'd2, 8'hFF, "R8 jumpers");

    // Command 1: interrupts enabled, drive select set
    host_wr(2'd3, 8'h02);
    host_wr(2'd2, 8'h00);
    host_rd(2'd1, 8'h0D, "R2 status after select");
    for (int i = 0; i < 5; i++) host_wr(2'd0, 8'(48'h000110052008 >> (i*8)));
    host_rd(2'd1, 8'h0D, "R2 still receiving");
    host_wr(2'd0, 8'h00);
    host_rd(2'd1, 8'h08, "R3 status after last byte");
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 dcb_valid held", 64'(dcb_valid), 64'd1);
    chk("R3 dcb_bytes", 64'(dcb_bytes), 64'h000110052008);
    take_dcb();
    @(negedge clk); chk("R3 dcb_valid drop", 64'(dcb_valid), 64'd0);
    host_wr(2'd0, 8'h55);
    @(negedge clk); chk("R4 sense after reject", 64'(sense_code), 64'h20);
    push_tx(8'hA5, "R9 tx_ready");
    host_rd(2'd1, 8'h0B, "R9 status byte held");
    @(negedge clk); chk("R9 drq off", 64'(drq), 64'd0);
    host_rd(2'd0, 8'hA5, "R9 data byte");
    host_rd(2'd1, 8'h08, "R9 status after pop");
    finish_cmd(1'b0, 8'h00);
    @(negedge clk); chk("R5 irq high", 64'(irq), 64'd1);
    host_rd(2'd1, 8'h2F, "R5 status with irq");
    host_rd(2'd0, 8'h22, "R6 completion drv+err");
    @(negedge clk); chk("R6 irq cleared", 64'(irq), 64'd0);
    host_rd(2'd1, 8'h00, "R6 status idle");

    // Command 2: DMA enabled, interrupts off, engine error
    host_wr(2'd3, 8'h01);
    host_wr(2'd2, 8'h00);
    send_dcb(48'h0000_0000_0008);
    take_dcb();
    push_tx(8'h3C, "R9 tx_ready dma");
    host_rd(2'd1, 8'h1B, "R9 status with drq");
    @(negedge clk); chk("R9 drq on", 64'(drq), 64'd1);
    host_rd(2'd0, 8'h3C, "R9 data byte dma");
    finish_cmd(1'b1, 8'h04);
    @(negedge clk);
    chk("R5 irq masked", 64'(irq), 64'd0);
    chk("R10 sense from engine", 64'(sense_code), 64'h04);
    host_rd(2'd1, 8'h0F, "R5 status no irq");
    host_rd(2'd0, 8'h02, "R10 completion err");

    // Command 3: restart mid-block, then reset port
    host_wr(2'd3, 8'h02);
    host_wr(2'd2, 8'h00);
    host_wr(2'd0, 8'h11); host_wr(2'd0, 8'h22); host_wr(2'd0, 8'h33);
    host_wr(2'd2, 8'h00);
    host_rd(2'd1, 8'h0D, "R2 restart status");
    send_dcb(48'h0403_0201_000B);
    @(negedge clk); chk("R2 restart dcb", 64'(dcb_bytes), 64'h0403_0201_000B);
    take_dcb();
    finish_cmd(1'b0, 8'h00);
    @(negedge clk); chk("R5 irq cmd3", 64'(irq), 64'd1);
    host_wr(2'd1, 8'h00);
    @(negedge clk);
    chk("R7 irq cleared", 64'(irq), 64'd0);
    chk("R7 sense cleared", 64'(sense_code), 64'h00);
    host_rd(2'd1, 8'h00, "R7 status idle");

    // Rejection in idle, then clean command clears error flag
    host_wr(2'd0, 8'h99);
    @(negedge clk); chk("R4 idle reject sense", 64'(sense_code), 64'h20);
    host_wr(2'd2, 8'h00);
    send_dcb(48'h0000_0000_0000);
    take_dcb();
    finish_cmd(1'b0, 8'h00);
    host_rd(2'd0, 8'h00, "R6 clean completion");
    host_rd(2'd1, 8'h00, "R6 idle after clean");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: %0d reads pending, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule